// File: doc/BRIEF.md
# Address-Event Spike Link

This block carries spikes from an array of neurons across one shared, narrow bus. Each neuron line pulses when that neuron fires, and the pulse is held as a pending event. A round-robin arbiter picks one pending neuron at a time. The transmitter puts the winner's binary index on the address bus and runs a four-phase request/acknowledge handshake with the receiver. Because every firing becomes one transfer, the only thing that carries a neuron's activity level is how often its index appears on the bus.

The same module also holds the receiving half. The receiver waits for an incoming request and samples the address. It then drives a one-cycle pulse on the matching output line and acknowledges. Both handshake inputs can come from another clock domain, so each passes through a two-flop synchroniser before any logic uses it. In a system, the transmit port of one instance drives the receive port of another. The bench closes that loop on a single instance.

Top module: `aer_link`

## Requirements
- R1: While rst_n is low and after it is released, ev_req_o is 0, ev_addr_o is 0, in_ack_o is 0 and fire_o is all zero until an event arrives.
- R2: A one-cycle high on spike_i[i] causes ev_req_o to rise on the second rising edge after the spike, with ev_addr_o equal to i written as an unsigned binary number. In loopback, exactly one pulse then appears on fire_o[i].
- R3: While ev_req_o stays high, ev_addr_o does not change.
- R4: The handshake is four-phase. ev_req_o falls on the third rising edge after ev_ack_i rises, and stays low while ev_ack_i is high. ev_req_o may rise again no earlier than the fourth rising edge after ev_ack_i falls.
- R5: The arbiter is round-robin. Its search starts at the index one above the last granted index, wrapping from N_UNITS-1 to 0, and it starts at 0 after reset. Neurons pending together therefore leave in ascending cyclic order from that start point.
- R6: Further spikes on a neuron whose event is still pending merge into that one event. A spike on a neuron arriving after its event was granted creates a new event.
- R7: When in_req_i rises, in_ack_o rises on the third rising edge after it, and fire_o pulses for exactly that one cycle. in_ack_o falls on the third rising edge after in_req_i falls.
- R8: An incoming address of N_UNITS or more is acknowledged as in R7, but no line of fire_o pulses.
- R9: A neuron that fires on every cycle cannot hold back another pending neuron. The other neuron is sent no later than the second transfer after its spike.
- R10: At most one bit of fire_o is high in any cycle, and no bit is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spike_i | input | N_UNITS | Per-neuron firing strobes |
| ev_req_o | output | 1 | Transmit request |
| ev_addr_o | output | AW | Transmit address, index of the sending neuron |
| ev_ack_i | input | 1 | Transmit acknowledge from the receiver (asynchronous) |
| in_req_i | input | 1 | Receive request from a transmitter (asynchronous) |
| in_addr_i | input | AW | Receive address, stable while in_req_i is high |
| in_ack_o | output | 1 | Receive acknowledge |
| fire_o | output | N_UNITS | One-cycle pulse on the decoded destination line |

## Verification
The bench builds the block with N_UNITS = 6. That makes the address 3 bits wide and leaves codes 6 and 7 unused, which exercises the out-of-range receive path. With six neurons, all 63 non-empty sets of simultaneous spikes can be applied in loopback. Each set starts from the arbiter pointer left by the previous one, so the delivery order is checked against many different wrap positions. Directed runs drive the handshake wires by hand to pin the synchroniser latencies, merging, and fairness against a neuron that never stops firing.

// File: rtl/aer_link.sv
module aer_link #(
  parameter int N_UNITS = 8,
  localparam int AW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] spike_i,
  output logic               ev_req_o,
  output logic [AW-1:0]      ev_addr_o,
  input  logic               ev_ack_i,
  input  logic               in_req_i,
  input  logic [AW-1:0]      in_addr_i,
  output logic               in_ack_o,
  output logic [N_UNITS-1:0] fire_o
);

  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_REL} tx_t;

  tx_t                tx_q;
  logic [N_UNITS-1:0] pend_q;
  logic [AW-1:0]      ptr_q;
  logic [AW-1:0]      addr_q;
  logic               ack_m, ack_s;
  logic               found;
  logic [AW-1:0]      win;
  logic               grant;
  logic [N_UNITS-1:0] clr;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N_UNITS; k++) begin
      if (!found && pend_q[(int'(ptr_q) + k) % N_UNITS]) begin
        found = 1'b1;
        win   = AW'((int'(ptr_q) + k) % N_UNITS);
      end
    end
  end

  assign grant = (tx_q == TX_IDLE) && found && !ack_s;
  assign clr   = {{(N_UNITS-1){1'b0}}, grant} << win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_m <= 1'b0;
      ack_s <= 1'b0;
    end else begin
      ack_m <= ev_ack_i;
      ack_s <= ack_m;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | spike_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= TX_IDLE;
      ptr_q  <= '0;
      addr_q <= '0;
    end else begin
      case (tx_q)
        TX_IDLE: if (grant) begin
          tx_q   <= TX_REQ;
          addr_q <= win;
          ptr_q  <= (int'(win) == N_UNITS - 1) ? '0 : win + 1'b1;
        end
        TX_REQ:  if (ack_s)  tx_q <= TX_REL;
        TX_REL:  if (!ack_s) tx_q <= TX_IDLE;
        default: tx_q <= TX_IDLE;
      endcase
    end
  end

  assign ev_req_o  = (tx_q == TX_REQ);
  assign ev_addr_o = addr_q;

  logic               req_m, req_s;
  logic               in_ack_q;
  logic [N_UNITS-1:0] fire_q;
  logic               in_range;

  assign in_range = int'(in_addr_i) < N_UNITS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_m    <= 1'b0;
      req_s    <= 1'b0;
      in_ack_q <= 1'b0;
      fire_q   <= '0;
    end else begin
      req_m  <= in_req_i;
      req_s  <= req_m;
      fire_q <= '0;
      if (!in_ack_q && req_s) begin
        in_ack_q <= 1'b1;
        if (in_range) fire_q <= {{(N_UNITS-1){1'b0}}, 1'b1} << in_addr_i;
      end else if (in_ack_q && !req_s) begin
        in_ack_q <= 1'b0;
      end
    end
  end

  assign in_ack_o = in_ack_q;
  assign fire_o   = fire_q;

endmodule

// File: rtl/aer_link_chk.sv
module aer_link_chk #(
  parameter int N_UNITS = 8,
  localparam int AW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_req_o,
  input logic [AW-1:0]      ev_addr_o,
  input logic               ev_ack_i,
  input logic               in_req_i,
  input logic               in_ack_o,
  input logic [N_UNITS-1:0] fire_o
);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_req_o && $past(ev_req_o) |-> $stable(ev_addr_o));

  p_req_fall_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ev_req_o) |-> $past(ev_ack_i, 2));

  p_req_rise_ack_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_req_o) |-> !$past(ev_ack_i, 2));

  p_ack_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack_o) |-> $past(in_req_i, 2));

  p_ack_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack_o) |-> !$past(in_req_i, 2));

  p_fire_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_o));

  p_fire_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_o) |=> (fire_o == '0));

  p_fire_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_o) |-> $rose(in_ack_o));

endmodule

bind aer_link aer_link_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_req_o(ev_req_o), .ev_addr_o(ev_addr_o),
  .ev_ack_i(ev_ack_i), .in_req_i(in_req_i), .in_ack_o(in_ack_o), .fire_o(fire_o)
);

// File: tb/tb_aer_link.sv
module tb_aer_link;
  localparam int N  = 6;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  spike;
  logic          ev_req, ev_ack, in_req, in_ack;
  logic [AW-1:0] ev_addr, in_addr;
  logic [N-1:0]  fire;
  logic          loop_en, tb_ack, tb_rreq;
  logic [AW-1:0] tb_raddr;

  assign ev_ack  = loop_en ? in_ack  : tb_ack;
  assign in_req  = loop_en ? ev_req  : tb_rreq;
  assign in_addr = loop_en ? ev_addr : tb_raddr;

  aer_link #(.N_UNITS(N)) dut (
    .clk(clk), .rst_n(rst_n), .spike_i(spike),
    .ev_req_o(ev_req), .ev_addr_o(ev_addr), .ev_ack_i(ev_ack),
    .in_req_i(in_req), .in_addr_i(in_addr), .in_ack_o(in_ack), .fire_o(fire)
  );

  int vec = 0, bad = 0, log_n = 0, mptr = 0;
  int log_a [0:1023];
  bit done = 0;

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (fire[i]) begin
        if (log_n < 1024) log_a[log_n] = i;
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_spike(input logic [N-1:0] m);
    @(negedge clk) spike = m;
    @(negedge clk) spike = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; spike = '0; loop_en = 1; tb_ack = 0; tb_rreq = 0; tb_raddr = '0;
    edges(4);
    chk(!ev_req && ev_addr == 0 && !in_ack && fire == 0, "R1 reset", int'(ev_req), 0);
    @(negedge clk) rst_n = 1;
    edges(3);
    chk(!ev_req && !in_ack && fire == 0, "R1 after release", int'(in_ack), 0);

    // R2 R5: every non-empty simultaneous spike set in loopback
    for (int m = 1; m < (1 << N); m++) begin
      int j;
      int cnt;
      log_n = 0;
      pulse_spike(N'(m));
      repeat (160) @(negedge clk);
      j = 0; cnt = 0;
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (mptr + k) % N;
        if (m[idx]) begin
          chk(log_a[j] == idx, "R5 order", log_a[j], idx);
          j++;
        end
      end
      for (int b = 0; b < N; b++) cnt += m[b];
      chk(log_n == cnt, "R2 pulse count", log_n, cnt);
      if (log_n > 0) mptr = (log_a[log_n - 1] + 1) % N;
    end

    // R2 R3 R4: transmitter with hand-driven acknowledge
    loop_en = 0; tb_ack = 0;
    @(negedge clk) spike = 6'b000100;
    @(negedge clk) spike = '0;
    #2;
    chk(!ev_req, "R2 req not yet", int'(ev_req), 0);
    edges(1);
    chk(ev_req && ev_addr == 2, "R2 req with addr 2", int'(ev_addr), 2);
    repeat (5) @(negedge clk);
    chk(ev_req && ev_addr == 2, "R3 addr held", int'(ev_addr), 2);
    @(negedge clk) tb_ack = 1;
    edges(2);
    chk(ev_req, "R4 req held two edges", int'(ev_req), 1);
    edges(1);
    chk(!ev_req, "R4 req drops third edge", int'(ev_req), 0);
    pulse_spike(6'b010000);
    repeat (6) @(negedge clk);
    chk(!ev_req, "R4 no new req while ack high", int'(ev_req), 0);
    @(negedge clk) tb_ack = 0;
    edges(3);
    chk(!ev_req, "R4 req low three edges after ack fall", int'(ev_req), 0);
    edges(1);
    chk(ev_req && ev_addr == 4, "R4 req rises fourth edge", int'(ev_addr), 4);
    @(negedge clk) tb_ack = 1;
    edges(4);
    @(negedge clk) tb_ack = 0;
    repeat (8) @(negedge clk);
    mptr = 5;

    // R7: receiver with hand-driven request
    log_n = 0;
    @(negedge clk) begin tb_raddr = 3'd5; tb_rreq = 1; end
    edges(2);
    chk(!in_ack && fire == 0, "R7 no ack at two edges", int'(in_ack), 0);
    edges(1);
    chk(in_ack && fire == 6'b100000, "R7 pulse line 5", int'(fire), 32);
    edges(1);
    chk(in_ack && fire == 0, "R7 pulse one cycle", int'(fire), 0);
    @(negedge clk) tb_rreq = 0;
    edges(2);
    chk(in_ack, "R7 ack held two edges", int'(in_ack), 1);
    edges(1);
    chk(!in_ack, "R7 ack drops third edge", int'(in_ack), 0);

    // R8: unused address codes
    for (int a = N; a < (1 << AW); a++) begin
      log_n = 0;
      @(negedge clk) begin tb_raddr = AW'(a); tb_rreq = 1; end
      edges(3);
      chk(in_ack && fire == 0, "R8 ack without pulse", int'(fire), 0);
      repeat (4) @(negedge clk);
      @(negedge clk) tb_rreq = 0;
      repeat (6) @(negedge clk);
      chk(!in_ack && log_n == 0, "R8 no line pulsed", log_n, 0);
    end

    // R6: merge while pending, new event once in flight
    loop_en = 1; log_n = 0;
    @(negedge clk) spike = 6'b000010;
    @(negedge clk) spike = 6'b001000;
    @(negedge clk) spike = 6'b001000;
    @(negedge clk) spike = 6'b000010;
    @(negedge clk) spike = '0;
    repeat (200) @(negedge clk);
    chk(log_n == 3, "R6 event count", log_n, 3);
    chk(log_a[0] == 1, "R6 first", log_a[0], 1);
    chk(log_a[1] == 3, "R6 merged once", log_a[1], 3);
    chk(log_a[2] == 1, "R6 re-fire", log_a[2], 1);
    mptr = 2;

    // R9: neuron 0 fires continuously, neuron 4 once
    log_n = 0;
    @(negedge clk) spike = 6'b000001;
    @(negedge clk) spike = 6'b010001;
    @(negedge clk) spike = 6'b000001;
    repeat (80) @(negedge clk);
    @(negedge clk) spike = '0;
    repeat (60) @(negedge clk);
    begin
      int n4;
      int pos4;
      n4 = 0; pos4 = -1;
      for (int k = 0; k < log_n; k++) if (log_a[k] == 4) begin n4++; if (pos4 < 0) pos4 = k; end
      chk(n4 == 1, "R9 neuron 4 sent once", n4, 1);
      chk(pos4 >= 0 && pos4 <= 1, "R9 within two transfers", pos4, 1);
      chk(log_n >= 3, "R9 neuron 0 keeps sending", log_n, 3);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule